// File: doc/BRIEF.md
# Configuration Table Register Loader

The loader walks a word-indexed configuration table and turns it into a series of register writes on a simple valid/ready bus. The first word of the table gives the address where writing begins. Each later word is one of three things: a data word, which is written to the current address before the address moves up by four bytes; a redirect marker, which makes the following table word the new current address; or a terminator, which ends the walk. Neither marker produces a bus write.

When the walk ends normally, the loader patches one fixed register at a set offset from a configured base address. It reads that register, replaces its low 17 bits with a parameter value, and writes the result back. It then pulses `done`. The walk stops and `err` pulses in two cases: the current address has dropped below the base address when the next word is about to be used, or the table runs out before a terminator is found. A single `start` pulse launches the whole sequence. `busy` covers the run.

Top module: `cfg_table_loader`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `busValid` are low.
- R2: Table word 0 is loaded as the current address and consuming data begins at index 1. Each data word is written (`busWrite`=1) to the current address, and the address then grows by 4.
- R3: A word equal to `END_CODE` (default 32'hFFFF_FFFF) ends the walk and causes no bus write of its own.
- R4: A word equal to `REDIR_CODE` (default 32'hFFFF_FFFE) makes the next table word the new current address. Neither of the two words is written.
- R5: If the current address is below `BASE_ADDR` when the next table word is about to be consumed, the run stops with an `err` pulse. No further bus access follows and no patch step takes place.
- R6: If the index reaches `TBL_DEPTH` before a terminator, the run ends with an `err` pulse and no patch step.
- R7: After a terminator, the loader issues one read (`busWrite`=0) of `BASE_ADDR+PATCH_OFFSET` (default offset 0x84). It then writes the same address with the read value's bits [16:0] replaced by `PATCH_VALUE` and bits [31:17] unchanged, and pulses `done`.
- R8: A bus request keeps `busValid`, `busWrite`, `busAddr` and `busWdata` steady until the cycle in which `busReady` is high. Bus wait states change neither the order nor the content of the writes.
- R9: `done` and `err` are single-cycle pulses and never high together. `busy` is high from the cycle after `start` until the pulse, and low during the pulse.
- R10: A `start` pulse while `busy` is high has no effect: the run's bus traffic is unchanged and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: walk and patch finished |
| err | output | 1 | One-cycle pulse: run aborted |
| tblIdx | output | IDX_W | Table word index being read |
| tblWord | input | WORD_W | Table word at `tblIdx`, same cycle |
| busValid | output | 1 | Bus request valid |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | WORD_W | Bus byte address |
| busWdata | output | WORD_W | Write data |
| busReady | input | 1 | Target accepts the request this cycle |
| busRdata | input | WORD_W | Read data, valid when `busReady` is high on a read |

## Verification
The assertions rely on three properties of the environment. `tblWord` must follow `tblIdx` combinationally and must not change while a run is in progress. `busRdata` must be valid in the cycle that accepts a read. `busReady` is never sampled while `busValid` is low. The bench meets all three: its table array stays fixed from before `start` until the end pulse, and its target model raises ready only after it sees a pending request, returning the patch register's preset value on reads. The target model can add a set number of wait states, so the same tables are run both with and without back-pressure.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrIdx;       // index back to word 0
    logic incIdx;       // step to next table word
    logic loadAddr;     // current address <= table word
    logic stepAddr;     // current address += one word
    logic selPatch;     // bus address/data come from the patch path
    logic capturePatch; // merge read data with patch value
  } loaderCtrl_t;

  typedef enum logic [3:0] {
    LD_IDLE,
    LD_FETCH,
    LD_WALK,
    LD_REDIR,
    LD_WRITE,
    LD_PATCH_RD,
    LD_PATCH_WR,
    LD_DONE,
    LD_FAIL
  } loaderState_t;

endpackage

// File: rtl/cfg_loader_dpath.sv
module cfg_loader_dpath
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned TBL_DEPTH    = 16,
  parameter logic [WORD_W-1:0] BASE_ADDR    = 32'h4000_0000,
  parameter logic [WORD_W-1:0] PATCH_OFFSET = 32'h0000_0084,
  parameter int unsigned PATCH_W      = 17,
  parameter logic [PATCH_W-1:0] PATCH_VALUE = 17'h00C30,
  parameter logic [WORD_W-1:0] END_CODE     = 32'hFFFF_FFFF,
  parameter logic [WORD_W-1:0] REDIR_CODE   = 32'hFFFF_FFFE,
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  loaderCtrl_t       ctrl,
  input  logic [WORD_W-1:0] tblWord,
  output logic [IDX_W-1:0]  tblIdx,
  input  logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  output logic              isEnd,
  output logic              isRedir,
  output logic              belowBase,
  output logic              tblSpent
);

  localparam logic [WORD_W-1:0] ADDR_STEP  = WORD_W'(4);
  localparam logic [WORD_W-1:0] PATCH_ADDR = BASE_ADDR + PATCH_OFFSET;
  localparam logic [WORD_W-1:0] PATCH_MASK = WORD_W'({PATCH_W{1'b1}});
  localparam logic [WORD_W-1:0] PATCH_BITS = WORD_W'(PATCH_VALUE);
  localparam logic [IDX_W-1:0]  IDX_LAST   = IDX_W'(TBL_DEPTH);

  logic [WORD_W-1:0] addrReg;
  logic [IDX_W-1:0]  idxReg;
  logic [WORD_W-1:0] patchReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
    end else if (ctrl.clrIdx) begin
      idxReg <= '0;
    end else if (ctrl.incIdx) begin
      idxReg <= idxReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctrl.loadAddr) begin
      addrReg <= tblWord;
    end else if (ctrl.stepAddr) begin
      addrReg <= addrReg + ADDR_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patchReg <= '0;
    end else if (ctrl.capturePatch) begin
      patchReg <= (busRdata & ~PATCH_MASK) | PATCH_BITS;
    end
  end

  assign tblIdx    = idxReg;
  assign busAddr   = ctrl.selPatch ? PATCH_ADDR : addrReg;
  assign busWdata  = ctrl.selPatch ? patchReg : tblWord;
  assign isEnd     = (tblWord == END_CODE);
  assign isRedir   = (tblWord == REDIR_CODE);
  assign belowBase = (addrReg < BASE_ADDR);
  assign tblSpent  = (idxReg == IDX_LAST);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepAddr |=> (addrReg - $past(addrReg)) == ADDR_STEP);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxReg <= IDX_LAST);

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isEnd,
  input  logic        isRedir,
  input  logic        belowBase,
  input  logic        tblSpent,
  input  logic        busReady,
  output loaderCtrl_t ctrl,
  output logic        busValid,
  output logic        busWrite,
  output logic        busy,
  output logic        done,
  output logic        err
);

  loaderState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= LD_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    busValid  = 1'b0;
    busWrite  = 1'b0;
    unique case (state)
      LD_IDLE: begin
        if (start) begin
          ctrl.clrIdx = 1'b1;
          nextState   = LD_FETCH;
        end
      end
      LD_FETCH: begin
        ctrl.loadAddr = 1'b1;
        ctrl.incIdx   = 1'b1;
        nextState     = LD_WALK;
      end
      LD_WALK: begin
        if (belowBase || tblSpent) begin
          nextState = LD_FAIL;
        end else if (isEnd) begin
          nextState = LD_PATCH_RD;
        end else if (isRedir) begin
          ctrl.incIdx = 1'b1;
          nextState   = LD_REDIR;
        end else begin
          nextState = LD_WRITE;
        end
      end
      LD_REDIR: begin
        if (tblSpent) begin
          nextState = LD_FAIL;
        end else begin
          ctrl.loadAddr = 1'b1;
          ctrl.incIdx   = 1'b1;
          nextState     = LD_WALK;
        end
      end
      LD_WRITE: begin
        busValid = 1'b1;
        busWrite = 1'b1;
        if (busReady) begin
          ctrl.stepAddr = 1'b1;
          ctrl.incIdx   = 1'b1;
          nextState     = LD_WALK;
        end
      end
      LD_PATCH_RD: begin
        busValid      = 1'b1;
        ctrl.selPatch = 1'b1;
        if (busReady) begin
          ctrl.capturePatch = 1'b1;
          nextState         = LD_PATCH_WR;
        end
      end
      LD_PATCH_WR: begin
        busValid      = 1'b1;
        busWrite      = 1'b1;
        ctrl.selPatch = 1'b1;
        if (busReady) nextState = LD_DONE;
      end
      LD_DONE: nextState = LD_IDLE;
      LD_FAIL: nextState = LD_IDLE;
      default: nextState = LD_IDLE;
    endcase
  end

  assign busy = (state != LD_IDLE) && (state != LD_DONE) && (state != LD_FAIL);
  assign done = (state == LD_DONE);
  assign err  = (state == LD_FAIL);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |=> !err);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> state != LD_FETCH);

endmodule

// File: rtl/cfg_table_loader.sv
module cfg_table_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned TBL_DEPTH    = 16,
  parameter logic [WORD_W-1:0] BASE_ADDR    = 32'h4000_0000,
  parameter logic [WORD_W-1:0] PATCH_OFFSET = 32'h0000_0084,
  parameter int unsigned PATCH_W      = 17,
  parameter logic [PATCH_W-1:0] PATCH_VALUE = 17'h00C30,
  parameter logic [WORD_W-1:0] END_CODE     = 32'hFFFF_FFFF,
  parameter logic [WORD_W-1:0] REDIR_CODE   = 32'hFFFF_FFFE,
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  tblIdx,
  input  logic [WORD_W-1:0] tblWord,
  output logic              busValid,
  output logic              busWrite,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [WORD_W-1:0] busRdata
);

  localparam logic [WORD_W-1:0] PATCH_ADDR = BASE_ADDR + PATCH_OFFSET;

  loaderCtrl_t ctrl;
  logic isEnd, isRedir, belowBase, tblSpent;

  cfg_loader_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .isEnd    (isEnd),
    .isRedir  (isRedir),
    .belowBase(belowBase),
    .tblSpent (tblSpent),
    .busReady (busReady),
    .ctrl     (ctrl),
    .busValid (busValid),
    .busWrite (busWrite),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  cfg_loader_dpath #(
    .WORD_W      (WORD_W),
    .TBL_DEPTH   (TBL_DEPTH),
    .BASE_ADDR   (BASE_ADDR),
    .PATCH_OFFSET(PATCH_OFFSET),
    .PATCH_W     (PATCH_W),
    .PATCH_VALUE (PATCH_VALUE),
    .END_CODE    (END_CODE),
    .REDIR_CODE  (REDIR_CODE)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .tblWord  (tblWord),
    .tblIdx   (tblIdx),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .isEnd    (isEnd),
    .isRedir  (isRedir),
    .belowBase(belowBase),
    .tblSpent (tblSpent)
  );

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid && $stable(busWrite)
                                && $stable(busAddr) && $stable(busWdata));

  // R7
  patch_read_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |-> busAddr == PATCH_ADDR);

  // R5
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busValid && !done);

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> !busy);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !busValid && !busy);

endmodule

// File: tb/cfg_table_loader_bench.sv
module cfg_table_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] PADDR = BASE + 32'h84;
  localparam logic [31:0] ENDW = 32'hFFFF_FFFF;
  localparam logic [31:0] REDW = 32'hFFFF_FFFE;
  localparam logic [31:0] PVAL = 32'h0000_0C30;
  localparam logic [31:0] PMASK = 32'h0001_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, err;
  logic [4:0] tblIdx;
  logic [31:0] tblWord;
  logic busValid, busWrite, busReady;
  logic [31:0] busAddr, busWdata, busRdata;

  logic [31:0] tbl [DEPTH];
  logic [31:0] wrAddr [64];
  logic [31:0] wrData [64];
  logic [31:0] expAddr [64];
  logic [31:0] expData [64];
  int wrN = 0, rdN = 0, expN = 0;
  logic [31:0] rdAddr = '0;
  logic [31:0] patchInit = 32'hA5A5_A5A5;
  int waitSet = 0;
  int waitCnt = 0;
  int tests = 0, fails = 0;
  bit sawDone, sawErr;

  assign tblWord = (tblIdx < 5'(DEPTH)) ? tbl[tblIdx[3:0]] : 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_table_loader u_cfg_table_loader (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .err(err),
    .tblIdx(tblIdx), .tblWord(tblWord), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata)
  );

  // Target model: accepts after waitSet wait states, logs transfers
  initial begin
    busReady = 1'b0;
    busRdata = '0;
    forever begin
      @(negedge clk);
      if (busValid && !busReady) begin
        if (waitCnt >= waitSet) begin
          busReady = 1'b1;
          waitCnt  = 0;
          if (busWrite) begin
            if (wrN < 64) begin
              wrAddr[wrN] = busAddr;
              wrData[wrN] = busWdata;
            end
            wrN++;
          end else begin
            rdN++;
            rdAddr   = busAddr;
            busRdata = patchInit;
          end
        end else begin
          waitCnt++;
        end
      end else begin
        busReady = 1'b0;
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearTbl();
    for (int i = 0; i < DEPTH; i++) tbl[i] = 32'h0;
    expN = 0;
  endtask

  task automatic expWr(input logic [31:0] a, input logic [31:0] d);
    expAddr[expN] = a;
    expData[expN] = d;
    expN++;
  endtask

  task automatic expPatch();
    expWr(PADDR, (patchInit & ~PMASK) | PVAL);
  endtask

  // Run the loaded table; optional second start while busy
  task automatic runTable(input bit midStart, input string req);
    int cyc;
    bit busyOk;
    wrN = 0; rdN = 0; waitCnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", 32'(busy), 32'h1);
    cyc = 0;
    busyOk = 1'b1;
    while (!(done || err) && cyc < 2000) begin
      if (!busy) busyOk = 1'b0;
      if (midStart && cyc == 2) start = 1'b1;
      if (cyc == 3) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    sawDone = done;
    sawErr  = err;
    chk(busyOk, "R9", "busy held until pulse", 32'(busyOk), 32'h1);
    chk(!busy && !(done && err), "R9", "busy low and single outcome at pulse",
        {30'h0, busy, done && err}, 32'h0);
    @(negedge clk);
    chk(!done && !err, "R9", "pulse width one cycle", {30'h0, done, err}, 32'h0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busValid || busy) begin
        chk(1'b0, "R10", "activity after run end", 32'(busValid), 32'h0);
        break;
      end
    end
    chk(wrN == expN, req, "write count", 32'(wrN), 32'(expN));
    for (int i = 0; i < expN && i < wrN; i++) begin
      chk(wrAddr[i] == expAddr[i], req, $sformatf("write %0d addr", i), wrAddr[i], expAddr[i]);
      chk(wrData[i] == expData[i], req, $sformatf("write %0d data", i), wrData[i], expData[i]);
    end
  endtask

  task automatic testReset();
    chk(!busy && !done && !err && !busValid, "R1", "idle after reset",
        {28'h0, busy, done, err, busValid}, 32'h0);
  endtask

  task automatic testLinear(input int ws, input string req);
    clearTbl();
    waitSet = ws;
    tbl[0] = BASE + 32'h10;
    tbl[1] = 32'h1111_0001; tbl[2] = 32'h2222_0002; tbl[3] = 32'h3333_0003;
    tbl[4] = ENDW;
    expWr(BASE + 32'h10, 32'h1111_0001);
    expWr(BASE + 32'h14, 32'h2222_0002);
    expWr(BASE + 32'h18, 32'h3333_0003);
    expPatch();
    runTable(1'b0, req);
    chk(sawDone && !sawErr, req, "done outcome", {30'h0, sawDone, sawErr}, 32'h2);
    chk(rdN == 1 && rdAddr == PADDR, "R7", "patch read address", rdAddr, PADDR);
    waitSet = 0;
  endtask

  task automatic testRedirect();
    clearTbl();
    tbl[0] = BASE + 32'h100; tbl[1] = 32'hD000_0001; tbl[2] = REDW;
    tbl[3] = BASE + 32'h200; tbl[4] = 32'hD000_0002; tbl[5] = 32'hD000_0003;
    tbl[6] = ENDW;
    expWr(BASE + 32'h100, 32'hD000_0001);
    expWr(BASE + 32'h200, 32'hD000_0002);
    expWr(BASE + 32'h204, 32'hD000_0003);
    expPatch();
    runTable(1'b0, "R4");
    chk(sawDone && !sawErr, "R4", "done outcome", {30'h0, sawDone, sawErr}, 32'h2);
  endtask

  task automatic testStartBelow();
    clearTbl();
    tbl[0] = BASE - 32'h4; tbl[1] = 32'h1234_5678; tbl[2] = ENDW;
    runTable(1'b0, "R5");
    chk(sawErr && !sawDone, "R5", "error outcome", {30'h0, sawDone, sawErr}, 32'h1);
    chk(rdN == 0, "R5", "no patch read", 32'(rdN), 32'h0);
  endtask

  task automatic testRedirBelow();
    clearTbl();
    tbl[0] = BASE; tbl[1] = 32'hCAFE_0001; tbl[2] = REDW;
    tbl[3] = 32'h0000_1000; tbl[4] = 32'hCAFE_0002; tbl[5] = ENDW;
    expWr(BASE, 32'hCAFE_0001);
    runTable(1'b0, "R5");
    chk(sawErr && !sawDone, "R5", "error after redirect", {30'h0, sawDone, sawErr}, 32'h1);
    chk(rdN == 0, "R5", "no patch read after redirect", 32'(rdN), 32'h0);
  endtask

  task automatic testImmediateEnd();
    clearTbl();
    patchInit = 32'hFFFF_FFFF;
    tbl[0] = BASE + 32'h40; tbl[1] = ENDW;
    expPatch();
    runTable(1'b0, "R3");
    chk(sawDone, "R7", "done with patch only", 32'(sawDone), 32'h1);
    patchInit = 32'hA5A5_A5A5;
  endtask

  task automatic testExhaust();
    clearTbl();
    tbl[0] = BASE + 32'h800;
    for (int i = 1; i < DEPTH; i++) begin
      tbl[i] = 32'h5A00_0000 + 32'(i);
      expWr(BASE + 32'h800 + 32'((i - 1) * 4), 32'h5A00_0000 + 32'(i));
    end
    runTable(1'b0, "R6");
    chk(sawErr && !sawDone, "R6", "error on exhausted table", {30'h0, sawDone, sawErr}, 32'h1);
    chk(rdN == 0, "R6", "no patch read", 32'(rdN), 32'h0);
  endtask

  task automatic testStartWhileBusy();
    clearTbl();
    tbl[0] = BASE + 32'h20; tbl[1] = 32'h7777_0001; tbl[2] = 32'h7777_0002;
    tbl[3] = ENDW;
    expWr(BASE + 32'h20, 32'h7777_0001);
    expWr(BASE + 32'h24, 32'h7777_0002);
    expPatch();
    runTable(1'b1, "R10");
    chk(rdN == 1, "R10", "single patch read", 32'(rdN), 32'h1);
  endtask

  initial begin
    clearTbl();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear(0, "R2");
    testLinear(3, "R8");
    testRedirect();
    testStartBelow();
    testRedirBelow();
    testImmediateEnd();
    testExhaust();
    testStartWhileBusy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule